// File: doc/BRIEF.md
# Move-Only Processor with Memory-Mapped Trigger Ports

This block is a small processor that executes exactly one kind of instruction: copy the word at a source address to a destination address. An instruction has no opcode. It is two consecutive memory words, the source address first and the destination address second. All computation and control flow come from side effects. The top sixteen addresses of the 256-word space are not storage but ports. Moving a word into one of them starts an ALU operation, loads the program counter, loads a condition, or stops the machine.

The ALU has an operand register and four trigger addresses. A move into a trigger address combines the operand with the moved word and stores the outcome in a result register, which programs read back as an ordinary source. Jumps are moves into the program counter port, either unconditional or gated by a condition register. A host loads the program and data through a synchronous memory port while the core is held in reset, starts it by releasing reset, waits for the halt output, and then reads the results back through the same port.

Port map (address: behaviour): 0xF0 program counter (read: address of the next instruction; write: jump); 0xF1 conditional jump target (write-only, reads 0); 0xF2 condition register; 0xF3 ALU operand A; 0xF4 add, 0xF5 subtract (A minus written word), 0xF6 AND, 0xF7 XOR (write: trigger; read: result); 0xF8 result (read-only); 0xF9 halt (write: stop; reads 0); 0xFA to 0xFF unused.

Top module: `move_cpu`

## Requirements
- R1: Each instruction at address p reads the source address from word p and the destination address from word p+1, and stores the word read at the source into the destination; between ordinary storage addresses (below 0xF0) the copy is exact.
- R2: A move whose destination is neither 0xF0 nor a taken conditional jump on 0xF1 advances the program counter by 2; reading 0xF0 as a source yields the current instruction address plus 2.
- R3: A move into 0xF0 sets the program counter to the low 8 bits of the moved word; the upper bits are discarded.
- R4: A move into 0xF1 loads the program counter with the low 8 bits of the moved word only when the condition register (0xF2, all 16 bits, readable) is nonzero; otherwise the program counter advances by 2.
- R5: 0xF3 holds ALU operand A; a move of word V into 0xF4, 0xF5, 0xF6 or 0xF7 sets the result to A+V, A-V, A AND V or A XOR V (modulo 2^16); the result reads back at 0xF8 and at each of 0xF4 to 0xF7.
- R6: A move into 0xF9 raises the halt output, which stays high until reset; no further instruction executes and no storage word is written by the core while halted.
- R7: While reset is high the halt output is low, the program counter is 0 (so 0xF0 reads 2), and the condition, operand and result registers read 0.
- R8: A host write to an address below 0xF0 is stored only while reset is high or the core is halted and is ignored while the core runs; a host read returns the addressed word (ports included) on the clock edge after the address is presented.
- R9: Addresses 0xFA to 0xFF and 0xF1 and 0xF9 read as 0; moves into 0xFA to 0xFF and into 0xF8 change no state.
- R10: Every executed instruction takes exactly 3 clock cycles, so a halt move that is the k-th executed instruction after reset is released raises the halt output on the 3k-th rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; holds the core idle |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| halted | output | 1 | High once a halt move has executed |

## Verification
On every cycle the assertions check the program counter update after each executed move (step by two, unconditional jump to the truncated word, conditional jump held back by a zero condition), the add result against the operand and moved word, the stickiness of the halt output with no core writes once halted, and the reset state of the program counter. Only the bench scenarios can show the end-to-end effect of whole programs: that copied words land at the right storage address, that skipped instructions leave memory untouched, that host writes during a run are lost while writes during reset are kept, that unused ports read zero, and that each instruction costs exactly three cycles.

// File: rtl/move_pkg.sv
package move_pkg;

    // Port window: the top 2**PORT_W addresses of the space.
    localparam int PORT_W = 4;

    localparam logic [PORT_W-1:0] P_PC   = 4'd0;
    localparam logic [PORT_W-1:0] P_CJMP = 4'd1;
    localparam logic [PORT_W-1:0] P_COND = 4'd2;
    localparam logic [PORT_W-1:0] P_OPA  = 4'd3;
    localparam logic [PORT_W-1:0] P_ADD  = 4'd4;
    localparam logic [PORT_W-1:0] P_SUB  = 4'd5;
    localparam logic [PORT_W-1:0] P_AND  = 4'd6;
    localparam logic [PORT_W-1:0] P_XOR  = 4'd7;
    localparam logic [PORT_W-1:0] P_RES  = 4'd8;
    localparam logic [PORT_W-1:0] P_HALT = 4'd9;

    // Low two bits of the trigger offset select the operation.
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_SRC  = 2'd0,
        ST_DST  = 2'd1,
        ST_EXEC = 2'd2
    } cpu_state_e;

    // Decoded view of an address.
    typedef struct packed {
        logic              is_port;
        logic [PORT_W-1:0] off;
    } port_dec_t;

endpackage

// File: rtl/move_ram.sv
module move_ram #(
    parameter int DW    = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 240
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = ({1'b0, raddr_a} < DEPTH_L) ? mem[raddr_a] : '0;
        rdata_b = ({1'b0, raddr_b} < DEPTH_L) ? mem[raddr_b] : '0;
    end
endmodule

// File: rtl/move_alu.sv
module move_alu
    import move_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_we,
    input  logic          trig_we,
    input  alu_op_e       op,
    input  logic [DW-1:0] wval,
    output logic [DW-1:0] opa,
    output logic [DW-1:0] result
);
    logic [DW-1:0] calc;

    always_comb begin
        unique case (op)
            OP_ADD:  calc = opa + wval;
            OP_SUB:  calc = opa - wval;
            OP_AND:  calc = opa & wval;
            OP_XOR:  calc = opa ^ wval;
            default: calc = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opa    <= '0;
            result <= '0;
        end else begin
            if (a_we) begin
                opa <= wval;
            end
            if (trig_we) begin
                result <= calc;
            end
        end
    end
endmodule

// File: rtl/move_rdmux.sv
module move_rdmux
    import move_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] ram_data,
    input  logic [AW-1:0] pc_next,
    input  logic [DW-1:0] cond,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] data
);
    port_dec_t dec;

    always_comb begin
        dec.is_port = &addr[AW-1:PORT_W];
        dec.off     = addr[PORT_W-1:0];
        data        = '0;
        if (!dec.is_port) begin
            data = ram_data;
        end else begin
            unique case (dec.off)
                P_PC:                          data = DW'(pc_next);
                P_COND:                        data = cond;
                P_OPA:                         data = opa;
                P_ADD, P_SUB, P_AND, P_XOR,
                P_RES:                         data = result;
                default:                       data = '0;
            endcase
        end
    end
endmodule

// File: rtl/move_ctrl.sv
module move_ctrl
    import move_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_word,
    input  logic          cond_nz,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] dst,
    output logic          exec,
    output logic          halted
);
    cpu_state_e state;
    logic [AW-1:0] src;
    port_dec_t dec;
    logic take;
    logic halt_hit;

    always_comb begin
        dec.is_port = &dst[AW-1:PORT_W];
        dec.off     = dst[PORT_W-1:0];
        exec        = (state == ST_EXEC) && !halted;
        take        = dec.is_port &&
                      ((dec.off == P_PC) || ((dec.off == P_CJMP) && cond_nz));
        halt_hit    = dec.is_port && (dec.off == P_HALT);
        unique case (state)
            ST_SRC:  rd_addr = pc;
            ST_DST:  rd_addr = pc + AW'(1);
            default: rd_addr = src;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_SRC;
            pc     <= '0;
            src    <= '0;
            dst    <= '0;
            halted <= 1'b0;
        end else if (!halted) begin
            unique case (state)
                ST_SRC: begin
                    src   <= rd_word;
                    state <= ST_DST;
                end
                ST_DST: begin
                    dst   <= rd_word;
                    state <= ST_EXEC;
                end
                default: begin
                    pc     <= take ? rd_word : pc + AW'(2);
                    halted <= halt_hit;
                    state  <= ST_SRC;
                end
            endcase
        end
    end
endmodule

// File: rtl/move_cpu.sv
module move_cpu
    import move_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          halted
);
    localparam int WORDS = 1 << AW;
    localparam int DEPTH = WORDS - (1 << PORT_W);

    logic [AW-1:0] pc, dst, rd_addr, pc_next;
    logic          exec;
    logic [DW-1:0] ram_core, ram_host, core_val, host_val;
    logic [DW-1:0] cond_q, opa, result;
    port_dec_t     ddec;
    logic          hport;
    logic          core_we, host_ok, ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;
    logic          a_we, trig_we;

    always_comb begin
        pc_next      = pc + AW'(2);
        ddec.is_port = &dst[AW-1:PORT_W];
        ddec.off     = dst[PORT_W-1:0];
        hport        = &host_addr[AW-1:PORT_W];
        core_we      = exec && !ddec.is_port;
        host_ok      = host_we && (rst || halted) && !hport;
        ram_we       = core_we || host_ok;
        ram_waddr    = core_we ? dst : host_addr;
        ram_wdata    = core_we ? core_val : host_wdata;
        a_we         = exec && ddec.is_port && (ddec.off == P_OPA);
        trig_we      = exec && ddec.is_port &&
                       (ddec.off >= P_ADD) && (ddec.off <= P_XOR);
    end

    move_ram #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (rd_addr),
        .rdata_a (ram_core),
        .raddr_b (host_addr),
        .rdata_b (ram_host)
    );

    move_rdmux #(.DW(DW), .AW(AW)) u_core_mux (
        .addr     (rd_addr),
        .ram_data (ram_core),
        .pc_next  (pc_next),
        .cond     (cond_q),
        .opa      (opa),
        .result   (result),
        .data     (core_val)
    );

    move_rdmux #(.DW(DW), .AW(AW)) u_host_mux (
        .addr     (host_addr),
        .ram_data (ram_host),
        .pc_next  (pc_next),
        .cond     (cond_q),
        .opa      (opa),
        .result   (result),
        .data     (host_val)
    );

    move_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rd_word (core_val[AW-1:0]),
        .cond_nz (|cond_q),
        .rd_addr (rd_addr),
        .pc      (pc),
        .dst     (dst),
        .exec    (exec),
        .halted  (halted)
    );

    move_alu #(.DW(DW)) u_alu (
        .clk     (clk),
        .rst     (rst),
        .a_we    (a_we),
        .trig_we (trig_we),
        .op      (alu_op_e'(ddec.off[1:0])),
        .wval    (core_val),
        .opa     (opa),
        .result  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
        end else if (exec && ddec.is_port && (ddec.off == P_COND)) begin
            cond_q <= core_val;
        end
    end

    always_ff @(posedge clk) begin
        host_rdata <= host_val;
    end
endmodule

// File: rtl/move_cpu_chk.sv
module move_cpu_chk
    import move_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          halted,
    input logic          exec,
    input logic [AW-1:0] dst,
    input logic [AW-1:0] pc,
    input logic [DW-1:0] core_val,
    input logic [DW-1:0] cond_q,
    input logic [DW-1:0] opa,
    input logic [DW-1:0] result,
    input logic          core_we
);
    logic              c_port;
    logic [PORT_W-1:0] c_off;
    logic              c_jump;

    always_comb begin
        c_port = &dst[AW-1:PORT_W];
        c_off  = dst[PORT_W-1:0];
        c_jump = c_port && ((c_off == P_PC) || ((c_off == P_CJMP) && (cond_q != '0)));
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        exec && !c_jump |=> pc == AW'($past(pc) + AW'(2)));                      // R2

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        exec && c_port && (c_off == P_PC) |=> pc == $past(core_val[AW-1:0])); // R3

    AST_CJMP_HELD: assert property (@(posedge clk) disable iff (rst)
        exec && c_port && (c_off == P_CJMP) && (cond_q == '0)
        |=> pc == AW'($past(pc) + AW'(2)));                                     // R4

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
        exec && c_port && (c_off == P_ADD)
        |=> result == DW'($past(opa) + $past(core_val)));                      // R5

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);                                                     // R6

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !core_we);                                                   // R6

    AST_RESET_PC: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0) && !halted);                                  // R7
endmodule

bind move_cpu move_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .halted   (halted),
    .exec     (exec),
    .dst      (dst),
    .pc       (pc),
    .core_val (core_val),
    .cond_q   (cond_q),
    .opa      (opa),
    .result   (result),
    .core_we  (core_we)
);

// File: tb/tb_move_cpu.sv
module tb_move_cpu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        halted;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ld = 0;

    move_cpu dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .halted(halted)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] alu_ref(input int op, input logic [15:0] a,
                                            input logic [15:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic hw(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        @(posedge clk);
        #1 d = host_rdata;
    endtask

    task automatic ins(input logic [7:0] s, input logic [7:0] d);
        hw(8'(ld), {8'h00, s});
        hw(8'(ld + 1), {8'h00, d});
        ld += 2;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        ld = 0;
    endtask

    task automatic run(output int n);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            #1 n++;
            if (halted) break;
        end
    endtask

    initial begin
        logic [15:0] d, a, b, e;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);

        // Reset state
        chk("R7 halt low in reset", int'(halted), 0);
        hr(8'hF0, d); chk("R7 pc port in reset", d, 2);
        hr(8'hF2, d); chk("R7 cond in reset", d, 0);
        hr(8'hF8, d); chk("R7 result in reset", d, 0);
        hr(8'hFA, d); chk("R9 unused port reads zero", d, 0);
        hr(8'hF9, d); chk("R9 halt port reads zero", d, 0);

        // Host write kept in reset, read latency
        hw(8'd230, 16'h4321);
        hr(8'd230, d); chk("R8 host write in reset", d, 16'h4321);

        // Plain moves
        hold_reset();
        hw(8'd200, 16'hC3A5); hw(8'd201, 16'h0000); hw(8'd202, 16'h0000);
        ins(8'd200, 8'd201); ins(8'd201, 8'd202); ins(8'd0, 8'hF9);
        run(n);
        chk("R10 three instr cycles", n, 9);
        chk("R6 halt raised", int'(halted), 1);
        hr(8'd201, d); chk("R1 first copy", d, 16'hC3A5);
        hr(8'd202, d); chk("R1 chained copy", d, 16'hC3A5);

        // ALU directed corners then random
        for (int it = 0; it < 28; it++) begin
            int op;
            op = it % 4;
            if (it < 4) begin a = 16'h0001; b = 16'hFFFF; end
            else begin a = 16'($urandom); b = 16'($urandom); end
            e = alu_ref(op, a, b);
            hold_reset();
            hw(8'd200, a); hw(8'd201, b);
            ins(8'd200, 8'hF3);
            ins(8'd201, 8'(8'hF4 + op));
            ins(8'hF8, 8'd202);
            ins(8'(8'hF4 + op), 8'd203);
            ins(8'd0, 8'hF9);
            run(n);
            chk("R10 five instr cycles", n, 15);
            hr(8'd202, d); chk("R5 result via 0xF8", d, e);
            hr(8'd203, d); chk("R5 result via trigger", d, e);
            hr(8'hF3, d); chk("R5 operand readback", d, a);
        end

        // Registers cleared by reset after use
        hold_reset();
        hr(8'hF3, d); chk("R7 operand cleared", d, 0);
        hr(8'hF8, d); chk("R7 result cleared", d, 0);

        // PC read
        hold_reset();
        ins(8'hF0, 8'd210); ins(8'hF0, 8'd211); ins(8'd0, 8'hF9);
        run(n);
        chk("R10 pc read program", n, 9);
        hr(8'd210, d); chk("R2 pc read at 0", d, 2);
        hr(8'd211, d); chk("R2 pc read at 2", d, 4);

        // Unconditional jump with high bits set
        hold_reset();
        hw(8'd220, 16'hAB0A); hw(8'd221, 16'h1111); hw(8'd212, 16'h0000);
        ins(8'd220, 8'hF0); ins(8'd221, 8'd212);
        ld = 10; ins(8'hF0, 8'd213); ins(8'd0, 8'hF9);
        run(n);
        chk("R3 jump skips path cycles", n, 9);
        hr(8'd212, d); chk("R3 skipped move not done", d, 0);
        hr(8'd213, d); chk("R3 jump landed at 10", d, 12);

        // Conditional jump, zero condition
        hold_reset();
        hw(8'd222, 16'h0000); hw(8'd223, 16'h5555); hw(8'd214, 16'h0000);
        ins(8'd222, 8'hF2); ins(8'd220, 8'hF1); ins(8'd223, 8'd214); ins(8'd0, 8'hF9);
        run(n);
        chk("R4 zero cond falls through cycles", n, 12);
        hr(8'd214, d); chk("R4 zero cond falls through", d, 16'h5555);

        // Conditional jump, nonzero condition in top bit only
        hold_reset();
        hw(8'd222, 16'h8000); hw(8'd214, 16'h0000); hw(8'd215, 16'h0000);
        ins(8'd222, 8'hF2); ins(8'd220, 8'hF1); ins(8'd223, 8'd214);
        ld = 10; ins(8'hF2, 8'd215); ins(8'd0, 8'hF9);
        run(n);
        chk("R4 taken cycles", n, 12);
        hr(8'd214, d); chk("R4 taken skips move", d, 0);
        hr(8'd215, d); chk("R4 cond readback", d, 16'h8000);

        // Halt stops everything after it
        hold_reset();
        hw(8'd224, 16'h0F0F); hw(8'd216, 16'h0000); hw(8'd217, 16'h0000);
        ins(8'd224, 8'd216); ins(8'd0, 8'hF9); ins(8'd224, 8'd217);
        run(n);
        chk("R10 halt as second instr", n, 6);
        repeat (20) @(posedge clk);
        #1 chk("R6 halt stays high", int'(halted), 1);
        hr(8'd216, d); chk("R6 move before halt", d, 16'h0F0F);
        hr(8'd217, d); chk("R6 no move after halt", d, 0);
        hw(8'd217, 16'h2468);
        hr(8'd217, d); chk("R8 host write while halted", d, 16'h2468);

        // Host write ignored while running (endless self jump)
        hold_reset();
        hw(8'd225, 16'h0000); hw(8'd218, 16'h1234);
        ins(8'd225, 8'hF0);
        @(negedge clk); rst = 1'b0;
        repeat (10) @(negedge clk);
        hw(8'd218, 16'hBEEF);
        repeat (5) @(negedge clk);
        chk("R6 self loop never halts", int'(halted), 0);
        hold_reset();
        hr(8'd218, d); chk("R8 host write during run ignored", d, 16'h1234);

        // Unused ports and result port writes
        hold_reset();
        hw(8'd226, 16'h7777); hw(8'd231, 16'hFFFF); hw(8'd232, 16'hFFFF);
        hw(8'd233, 16'hFFFF);
        ins(8'd226, 8'hFA); ins(8'hFA, 8'd231); ins(8'd226, 8'hF8);
        ins(8'hF8, 8'd232); ins(8'hFF, 8'd233); ins(8'd0, 8'hF9);
        run(n);
        chk("R10 six instr cycles", n, 18);
        hr(8'd231, d); chk("R9 unused port after write", d, 0);
        hr(8'd232, d); chk("R9 result port write ignored", d, 0);
        hr(8'd233, d); chk("R9 top port reads zero", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule